// File: doc/BRIEF.md
# Configurable-Mode SPI Frame Master

This block is the master side of a serial peripheral link. It takes words of 4 to 16 bits from a transmit queue and shifts each one out most significant bit first. It samples the receive line at the same time and hands each received word to a receive queue. Both queues sit outside the block and connect through plain valid/ready style handshake ports. The block generates the serial clock from a programmable divider. It drives an active-low frame select and controls the output enable of the transmit line so that the line floats while no frame is in progress.

Clock polarity and clock phase can each be set to either value. Polarity sets the level at which the serial clock rests. Phase selects whether data is captured on the first edge of each bit or on the second. A frame can carry a single word. A frame can also run words back to back, with frame select held low between them for as long as the transmit queue keeps supplying data. The configuration inputs are read only when a frame starts, so software can change them at any time without corrupting a frame that is running.

Top module: `spi_frame_master`

## Requirements
- R1: The word length is N = wlen_i+1. A wlen_i value below 3 gives N = 4, so N ranges from 4 to 16. Bit N-1 of tx_data_i goes out first on mosi_o. The first bit received lands in bit N-1 of rx_data_o.
- R2: Out of reset and whenever no frame is running, cs_no is 1, mosi_oe_o is 0 and mosi_o is 0.
- R3: While idle, sclk_o takes the value cpol_i had on the previous system clock edge. When a frame ends, sclk_o holds the polarity that frame used until the first idle edge.
- R4: A frame starts only on a system clock edge where the block is idle and both en_i and tx_valid_i are 1. tx_ready_o is 1 in that cycle. On that edge cs_no goes to 0 and mosi_oe_o goes to 1.
- R5: The first sclk_o transition comes one half-period after cs_no falls. With phase 0, bit N-1 is on mosi_o from the moment cs_no falls.
- R6: Serial clock edges are numbered 1 to 2N within a word. With cpha_i = 0, data is captured on odd edges and a new bit is launched on even edges other than 2N. With cpha_i = 1, a new bit is launched on odd edges from edge 3 onward and data is captured on even edges.
- R7: After the last capture of a word, cs_no rises exactly two half-periods later. sclk_o is back at its rest level by then.
- R8: At the point where cs_no would rise, if en_i and tx_valid_i are both 1, the next word is taken (tx_ready_o is 1). cs_no then stays 0 and a new lead half-period begins.
- R9: One half-period lasts H = max(div_i,1)+1 system clocks, so one serial clock period is 2H.
- R10: cpol_i, cpha_i, wlen_i and div_i are sampled only on the edge that starts a frame. The sampled values hold across all back-to-back words of that frame, and changes made during the frame have no effect.
- R11: On the final capture edge of a word, the received word is pushed. rx_valid_o is 1 for the single cycle after that edge, and rx_data_o holds the word right-aligned with the bits above N-1 equal to zero.
- R12: If rx_full_i is 1 on the final capture edge, the word is dropped and no rx_valid_o pulse is made. overrun_o is set and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Allows new words to be taken |
| cpol_i | input | 1 | Clock rest level |
| cpha_i | input | 1 | 0: capture on odd edges, 1: capture on even edges |
| wlen_i | input | 4 | Word length minus one |
| div_i | input | 8 | Half-period divider (0 is treated as 1) |
| tx_valid_i | input | 1 | Transmit queue has a word |
| tx_data_i | input | 16 | Word at the head of the transmit queue |
| tx_ready_o | output | 1 | Word is taken on this edge when tx_valid_i is 1 |
| rx_valid_o | output | 1 | One-cycle push of a received word |
| rx_data_o | output | 16 | Received word, right-aligned |
| rx_full_i | input | 1 | Receive queue cannot accept a word |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Frame select, active low |
| mosi_o | output | 1 | Transmit data |
| mosi_oe_o | output | 1 | Output enable for the transmit line |
| miso_i | input | 1 | Receive data |
| overrun_o | output | 1 | Sticky flag: a received word was dropped |

## Verification
The hardest situation to reach from the ports is the end of a word when the transmit queue is already holding the next word. The decision to take the next word and the decision to raise frame select fall on the same system clock edge, so the queue has to be loaded before the frame starts for the words to chain. The bench therefore holds en_i low, fills the queue, and only then raises en_i. The same approach is used to change the configuration inputs while frame select is low: the bench waits for frame select to fall and then alters every configuration input. A reference model runs in step with the design, and it flags any cycle in which the clock, data or frame select depart from the timing sampled at the start of the frame.

// File: rtl/spi_pkg.sv
package spi_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} spi_state_e;
  localparam int unsigned SPI_MIN_W = 4;
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_edge_decode.sv
module spi_edge_decode #(
  parameter int unsigned STEP_W = 6
) (
  input  logic [STEP_W-1:0] k_i,
  input  logic [STEP_W-1:0] two_n_i,
  input  logic              cpha_i,
  output logic              edge_o,
  output logic              cap_o,
  output logic              last_o,
  output logic              launch_o,
  output logic              done_o
);
  logic odd;
  assign odd      = k_i[0];
  assign edge_o   = (k_i != '0) && (k_i <= two_n_i);
  assign cap_o    = edge_o && (cpha_i ? !odd : odd);
  assign last_o   = cap_o && (cpha_i ? (k_i == two_n_i) : (k_i == two_n_i - STEP_W'(1)));
  assign launch_o = edge_o && (cpha_i ? (odd && k_i != STEP_W'(1)) : (!odd && k_i != two_n_i));
  // tail: one half after the return edge (phase 0) or two halves (phase 1)
  assign done_o   = k_i == (two_n_i + (cpha_i ? STEP_W'(2) : STEP_W'(1)));
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter  int unsigned MAX_W = 16,
  localparam int unsigned LEN_W = $clog2(MAX_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [MAX_W-1:0] data_i,
  input  logic             shift_i,
  input  logic [LEN_W-1:0] msb_idx_i,
  output logic             bit_o
);
  logic [MAX_W-1:0] sr_q;

  assign bit_o = sr_q[msb_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= data_i;
    else if (shift_i) sr_q <= {sr_q[MAX_W-2:0], 1'b0};
  end
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
  parameter int unsigned MAX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             cap_i,
  input  logic             bit_i,
  output logic [MAX_W-1:0] word_o
);
  logic [MAX_W-2:0] sr_q;

  assign word_o = {sr_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sr_q <= '0;
    else if (clr_i) sr_q <= '0;
    else if (cap_i) sr_q <= word_o[MAX_W-2:0];
  end
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spi_pkg::*;
#(
  parameter  int unsigned MAX_W  = 16,
  parameter  int unsigned DIV_W  = 8,
  localparam int unsigned LEN_W  = $clog2(MAX_W),
  localparam int unsigned CNT_W  = $clog2(MAX_W + 1),
  localparam int unsigned STEP_W = $clog2(2 * MAX_W + 3)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic [LEN_W-1:0] wlen_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tx_valid_i,
  input  logic [MAX_W-1:0] tx_data_i,
  output logic             tx_ready_o,
  output logic             rx_valid_o,
  output logic [MAX_W-1:0] rx_data_o,
  input  logic             rx_full_i,
  output logic             sclk_o,
  output logic             cs_no,
  output logic             mosi_o,
  output logic             mosi_oe_o,
  input  logic             miso_i,
  output logic             overrun_o
);
  spi_state_e       state_q;
  logic             cfg_cpol_q, cfg_cpha_q;
  logic [CNT_W-1:0] cfg_len_q;
  logic [DIV_W-1:0] cfg_div_q;
  logic [STEP_W-1:0] step_q, step_k, two_n;
  logic             sclk_q, cs_n_q, oe_q, rx_valid_q, ovr_q;
  logic [MAX_W-1:0] rx_data_q, rx_word;
  logic             run, tick, take, tx_bit;
  logic             edge_e, cap_e, last_e, launch_e, done_e;
  logic [CNT_W-1:0] len_in;
  logic [DIV_W-1:0] div_in;
  logic [LEN_W-1:0] msb_idx;

  assign run     = (state_q == ST_RUN);
  assign step_k  = step_q + STEP_W'(1);
  assign two_n   = STEP_W'({cfg_len_q, 1'b0});
  assign msb_idx = LEN_W'(cfg_len_q - CNT_W'(1));

  // configuration clamps applied at frame start
  assign len_in = (wlen_i < LEN_W'(SPI_MIN_W - 1)) ? CNT_W'(SPI_MIN_W)
                                                   : CNT_W'(wlen_i) + CNT_W'(1);
  assign div_in = (div_i == '0) ? DIV_W'(1) : div_i;

  assign tx_ready_o = en_i && (!run || (tick && done_e));
  assign take       = tx_ready_o && tx_valid_i;

  spi_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (cfg_div_q),
    .tick_o (tick)
  );

  spi_edge_decode #(.STEP_W(STEP_W)) u_dec (
    .k_i      (step_k),
    .two_n_i  (two_n),
    .cpha_i   (cfg_cpha_q),
    .edge_o   (edge_e),
    .cap_o    (cap_e),
    .last_o   (last_e),
    .launch_o (launch_e),
    .done_o   (done_e)
  );

  spi_tx_shift #(.MAX_W(MAX_W)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (take),
    .data_i    (tx_data_i),
    .shift_i   (run && tick && launch_e),
    .msb_idx_i (msb_idx),
    .bit_o     (tx_bit)
  );

  spi_rx_shift #(.MAX_W(MAX_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (take),
    .cap_i  (run && tick && cap_e),
    .bit_i  (miso_i),
    .word_o (rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cfg_cpol_q <= 1'b0;
      cfg_cpha_q <= 1'b0;
      cfg_len_q  <= CNT_W'(SPI_MIN_W);
      cfg_div_q  <= DIV_W'(1);
      step_q     <= '0;
      sclk_q     <= 1'b0;
      cs_n_q     <= 1'b1;
      oe_q       <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
      ovr_q      <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          sclk_q <= cpol_i;
          if (take) begin
            cfg_cpol_q <= cpol_i;
            cfg_cpha_q <= cpha_i;
            cfg_len_q  <= len_in;
            cfg_div_q  <= div_in;
            cs_n_q     <= 1'b0;
            oe_q       <= 1'b1;
            step_q     <= '0;
            state_q    <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (tick) begin
            step_q <= step_k;
            if (edge_e) sclk_q <= ~sclk_q;
            if (last_e) begin
              if (rx_full_i) ovr_q <= 1'b1;
              else begin
                rx_valid_q <= 1'b1;
                rx_data_q  <= rx_word;
              end
            end
            if (done_e) begin
              if (take) step_q <= '0;
              else begin
                state_q <= ST_IDLE;
                cs_n_q  <= 1'b1;
                oe_q    <= 1'b0;
              end
            end
          end
        end
      endcase
    end
  end

  assign sclk_o     = sclk_q;
  assign cs_no      = cs_n_q;
  assign mosi_oe_o  = oe_q;
  assign mosi_o     = oe_q & tx_bit;
  assign rx_valid_o = rx_valid_q;
  assign rx_data_o  = rx_data_q;
  assign overrun_o  = ovr_q;
endmodule

// File: rtl/spi_frame_master_chk.sv
module spi_frame_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic tx_valid_i,
  input logic cpol_i,
  input logic cs_no,
  input logic sclk_o,
  input logic mosi_oe_o,
  input logic rx_valid_o,
  input logic overrun_o
);
  logic warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warm_q <= 1'b0;
    else         warm_q <= 1'b1;
  end

  a_r2_idle_tristate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !mosi_oe_o);

  a_r3_idle_clk_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_q && cs_no && $past(cs_no) |-> sclk_o == $past(cpol_i));

  a_r4_start_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(en_i && tx_valid_i));

  a_r9_half_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no && !$stable(sclk_o) |=> $stable(sclk_o));

  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  a_r12_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
endmodule

bind spi_frame_master spi_frame_master_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .tx_valid_i (tx_valid_i),
  .cpol_i     (cpol_i),
  .cs_no      (cs_no),
  .sclk_o     (sclk_o),
  .mosi_oe_o  (mosi_oe_o),
  .rx_valid_o (rx_valid_o),
  .overrun_o  (overrun_o)
);

// File: tb/sim_spi_frame_master.sv
`timescale 1ns/1ps
module sim_spi_frame_master;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0, cpol_i = 1'b0, cpha_i = 1'b0;
  logic [3:0]  wlen_i = 4'd7;
  logic [7:0]  div_i = 8'd1;
  logic        tx_valid_i = 1'b0;
  logic [15:0] tx_data_i = '0;
  logic        tx_ready_o, rx_valid_o, sclk_o, cs_no, mosi_o, mosi_oe_o, overrun_o;
  logic [15:0] rx_data_o;
  logic        rx_full_i = 1'b0;
  logic        miso_i = 1'b0;

  always #2.5 clk = ~clk;

  spi_frame_master u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .cpol_i(cpol_i), .cpha_i(cpha_i),
    .wlen_i(wlen_i), .div_i(div_i), .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i),
    .tx_ready_o(tx_ready_o), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
    .rx_full_i(rx_full_i), .sclk_o(sclk_o), .cs_no(cs_no), .mosi_o(mosi_o),
    .mosi_oe_o(mosi_oe_o), .miso_i(miso_i), .overrun_o(overrun_o)
  );

  int errs = 0, checks = 0, cyc = 0, rx_seen = 0, rx_expect = 0;
  logic [15:0] q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp_v, $time);
    end
  endtask

  // reference model state
  bit          m_run = 0, m_cpol = 0, m_cpha = 0;
  int          t = 0, mh = 2, mn = 4;
  logic [15:0] m_word = '0, m_sw = '0, e_rxd = '0;
  bit          e_sclk = 0, e_rxv = 0, e_ovr = 0;

  function automatic logic [15:0] slave_of(input logic [15:0] w);
    return (w ^ 16'hC3A5) + 16'h0137;
  endfunction

  function automatic logic [15:0] mask_of(input int n);
    return 16'((32'd1 << n) - 1);
  endfunction

  task automatic m_load();
    m_word = tx_data_i;
    m_sw   = slave_of(tx_data_i);
    void'(q.pop_front());
    t      = 0;
    m_run  = 1;
  endtask

  always @(posedge clk) begin
    int k;
    if (!rst_ni) begin
      m_run = 0; e_rxv = 0; e_ovr = 0; e_sclk = 0;
    end else begin
      e_rxv = 0;
      if (!m_run) begin
        e_sclk = cpol_i;
        if (en_i && tx_valid_i) begin
          m_cpol = cpol_i;
          m_cpha = cpha_i;
          mn = (int'(wlen_i) + 1 < 4) ? 4 : int'(wlen_i) + 1;
          mh = ((div_i == 0) ? 1 : int'(div_i)) + 1;
          m_load();
        end
      end else begin
        t++;
        if (t % mh == 0) begin
          k = t / mh;
          if (k == (m_cpha ? 2*mn : 2*mn - 1)) begin
            if (!rx_full_i) begin e_rxv = 1; e_rxd = m_sw & mask_of(mn); end
            else e_ovr = 1;
          end
          if (k == 2*mn + (m_cpha ? 2 : 1)) begin
            if (en_i && tx_valid_i) m_load();
            else begin m_run = 0; e_sclk = m_cpol; end
          end
        end
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // per-cycle comparison and input drive
  always @(negedge clk) begin
    int h, edges, b;
    bit es;
    cyc++;
    if (rst_ni) begin
      h = t / mh;
      edges = (h < 2*mn) ? h : 2*mn;
      chk(cs_no == !m_run, "R2/R4/R5/R7/R8 frame select", cs_no, !m_run);
      chk(mosi_oe_o == m_run, "R2/R4 driver enable", mosi_oe_o, m_run);
      es = m_run ? (m_cpol ^ edges[0]) : e_sclk;
      chk(sclk_o == es, "R3/R5/R6/R9/R10 serial clock", sclk_o, es);
      if (m_run) begin
        if (!m_cpha) b = edges / 2;
        else         b = (edges <= 1) ? 0 : (edges - 1) / 2;
        if (b > mn - 1) b = mn - 1;
        chk(mosi_o == m_word[mn-1-b], "R1/R5/R6 transmit bit", mosi_o, m_word[mn-1-b]);
      end else begin
        chk(mosi_o == 1'b0, "R2 idle data low", mosi_o, 0);
      end
      chk(rx_valid_o == e_rxv, "R11/R12 receive strobe", rx_valid_o, e_rxv);
      if (e_rxv) chk(rx_data_o == e_rxd, "R1/R11 receive word", rx_data_o, e_rxd);
      chk(overrun_o == e_ovr, "R12 overrun flag", overrun_o, e_ovr);
      if (rx_valid_o) rx_seen++;
    end
    tx_valid_i = (q.size() != 0);
    tx_data_i  = (q.size() != 0) ? q[0] : 16'h0;
    if (m_run) begin
      b = (t / mh) / 2;
      if (b > mn - 1) b = mn - 1;
      miso_i = m_sw[mn-1-b];
    end else miso_i = 1'b0;
    if (cyc > 100000) begin
      errs++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic wait_idle();
    int guard = 0;
    do begin @(negedge clk); guard++; end
    while ((m_run || q.size() != 0) && guard < 20000);
    repeat (4) @(negedge clk);
  endtask

  task automatic set_cfg(input bit pol, input bit pha, input logic [3:0] wl, input logic [7:0] dv);
    cpol_i = pol; cpha_i = pha; wlen_i = wl; div_i = dv;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk(cs_no == 1'b1, "R2 reset frame select", cs_no, 1);
    chk(mosi_oe_o == 1'b0, "R2 reset driver", mosi_oe_o, 0);
    chk(rx_valid_o == 1'b0, "R11 reset strobe", rx_valid_o, 0);
    chk(overrun_o == 1'b0, "R12 reset flag", overrun_o, 0);

    // R4: data waiting but disabled
    q.push_back(16'h00A5);
    repeat (40) @(negedge clk);
    chk(cs_no == 1'b1, "R4 no start while disabled", cs_no, 1);

    // R6 polarity 0 phase 0, 8 bits
    set_cfg(0, 0, 4'd7, 8'd1);
    en_i = 1'b1;
    rx_expect += 1;
    wait_idle();

    // R3: idle clock follows polarity
    cpol_i = 1'b1;
    repeat (6) @(negedge clk);
    chk(sclk_o == 1'b1, "R3 idle clock level", sclk_o, 1);

    // R8 back-to-back, polarity 0 phase 1, 16 bits
    en_i = 1'b0;
    set_cfg(0, 1, 4'd15, 8'd2);
    q.push_back(16'hBEEF); q.push_back(16'h1234); q.push_back(16'h8001);
    repeat (3) @(negedge clk);
    en_i = 1'b1;
    rx_expect += 3;
    wait_idle();

    // R9 divider 0 clamps to 1, polarity 1 phase 0, 4 bits
    set_cfg(1, 0, 4'd3, 8'd0);
    q.push_back(16'h000C);
    rx_expect += 1;
    wait_idle();

    // R1 short length clamps to 4, polarity 1 phase 1
    set_cfg(1, 1, 4'd1, 8'd3);
    q.push_back(16'hFFF6);
    rx_expect += 1;
    wait_idle();

    // R10 configuration changed while frame select is low
    set_cfg(0, 1, 4'd11, 8'd2);
    q.push_back(16'h0ABC); q.push_back(16'h0F0F);
    while (cs_no) @(negedge clk);
    set_cfg(1, 0, 4'd3, 8'd5);
    rx_expect += 2;
    wait_idle();

    // R12 receive queue full: word dropped, flag sticky
    set_cfg(0, 0, 4'd9, 8'd1);
    rx_full_i = 1'b1;
    q.push_back(16'h02D3);
    wait_idle();
    chk(overrun_o == 1'b1, "R12 overrun set", overrun_o, 1);
    rx_full_i = 1'b0;
    q.push_back(16'h0155);
    rx_expect += 1;
    wait_idle();
    chk(overrun_o == 1'b1, "R12 overrun sticky", overrun_o, 1);

    chk(rx_seen == rx_expect, "R11/R12 receive push count", rx_seen, rx_expect);
    summary();
  end
endmodule